// File: doc/BRIEF.md
# Serial Result Shift Port

This block presents a latched 18-bit conversion result on a single serial data line, most significant bit first. It works either as a clock master, generating its own serial clock and a frame-sync strobe from the system clock, or as a clock slave, shifting on edges of an external serial clock that chip select gates. Strap-style inputs choose the clock source, the polarity of the frame sync, which serial clock edge updates the data, and, for the master, whether the word goes out during the next conversion or only once the current one has finished. In master read-after-conversion mode a 2-bit code sets the serial clock rate.

The surrounding converter reports the start of each conversion and its completion with the new result. In master read-after-conversion the busy output is held until the word has been sent. In slave mode a second device's serial output can be chained into the data input. Its bits then follow the local word. A slave read cut short by the next completed conversion raises a one-cycle error flag.

Top module: `serial_result_port`

## Requirements
- R1: In master mode a frame carries exactly 18 serial clock periods. The result goes out MSB first. The data changes only on the update edge of the raw clock, which idles low and rises first. The receiver samples on the opposite edge.
- R2: In master mode the frame sync is active for the whole frame and inactive otherwise. It is active high when sync_inv_i is 0 and active low when it is 1.
- R3: sclk_inv_i inverts the serial clock. With it at 0, data updates on the rising edge of sclk_o and sclk_o idles low. With it at 1 the edges swap and sclk_o idles high. The same input selects the active edge of sclk_i in slave mode.
- R4: Master read-after-conversion (rd_during_i=0) starts a frame with the new result on the cycle the conversion completes. busy_o rises when a conversion starts and stays high until the frame sync goes inactive, falling on that same cycle.
- R5: Master read-during-conversion (rd_during_i=1) sends the previously completed result, starting when the next conversion starts. It always uses the fastest clock code. busy_o falls when that conversion completes, even while the frame continues.
- R6: Clock code div_sel_i = 0, 1, 2 and 3 gives a half period of HALF_DIV0..HALF_DIV3 system clocks. The defaults are 3, 8, 15 and 30, about 25, 60, 120 and 240 ns per period at 250 MHz. The code is captured at frame start.
- R7: In slave mode, completion of a conversion loads the result, and sdout_o shows the MSB. Each active edge of sclk_i seen while cs_ni is low advances one bit. Edges seen while cs_ni is high have no effect.
- R8: In slave mode the level of sdin_i at each active edge is shifted in, so the bit taken on the k-th edge appears on sdout_o after 18 more edges.
- R9: If a slave read has taken between 1 and 17 active edges when a conversion completes, rd_err_o pulses high for exactly one cycle and the new result replaces the unread data. A completed read or an untouched word raises no error.
- R10: While cs_ni is high, the data, clock and sync output enables are all low. The clock and sync enables are high only in master mode with cs_ni low.
- R11: After reset busy_o and rd_err_o are low, the master clock is idle and the frame sync is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | One-cycle pulse: a conversion begins |
| conv_done_i | input | 1 | One-cycle pulse: a conversion finished, result_i valid |
| result_i | input | 18 | Conversion result |
| slave_mode_i | input | 1 | 0 master (internal clock), 1 slave (external clock) |
| sync_inv_i | input | 1 | 1 makes the frame sync active low |
| sclk_inv_i | input | 1 | Swaps the serial clock update and sample edges |
| rd_during_i | input | 1 | Master: 1 read during next conversion, 0 read after conversion |
| div_sel_i | input | 2 | Master read-after-conversion clock code |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | External serial clock (slave) |
| sdin_i | input | 1 | Chained serial data input (slave) |
| sclk_o | output | 1 | Generated serial clock (master) |
| sclk_oe_o | output | 1 | Output enable for sclk_o |
| sync_o | output | 1 | Frame sync (master) |
| sync_oe_o | output | 1 | Output enable for sync_o |
| sdout_o | output | 1 | Serial data output |
| sdout_oe_o | output | 1 | Output enable for sdout_o |
| busy_o | output | 1 | Conversion (and master post-conversion read) in progress |
| rd_err_o | output | 1 | One-cycle pulse: slave read cut short |

## Verification
Two events can land together. In master read-during-conversion, the next conversion can complete while the earlier word is still going out. The bench raises the completion strobe forty cycles into such a frame and checks three things: busy_o falls at once, the frame sync stays active, and every remaining bit still matches the old word. The next frame must then carry the new result. In slave mode the same strobe is raised after five active edges. The bench then expects exactly one error pulse and the new MSB on the data line, and a later full read completes cleanly with no further pulse.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned RES_W = 18;

  typedef enum logic [1:0] {
    DIV_C0 = 2'd0,
    DIV_C1 = 2'd1,
    DIV_C2 = 2'd2,
    DIV_C3 = 2'd3
  } div_code_e;
endpackage

// File: rtl/srp_master_clk.sv
module srp_master_clk #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned CW     = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] half_i,
  output logic          sclk_o,
  output logic          frame_o,
  output logic          shift_o,
  output logic          done_o
);
  localparam int unsigned HALVES = 2 * WORD_W;
  localparam int unsigned EW     = $clog2(HALVES + 1);

  logic [CW-1:0] hc_q, half_q;
  logic [EW-1:0] ec_q;
  logic          sclk_q, frame_q, expire;

  assign expire  = frame_q && (hc_q == half_q - CW'(1));
  assign done_o  = expire && (ec_q == EW'(HALVES));
  // rising raw edge, except the first, advances the word
  assign shift_o = expire && !done_o && !sclk_q && (ec_q != '0);
  assign sclk_o  = sclk_q;
  assign frame_o = frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q    <= '0;
      half_q  <= CW'(1);
      ec_q    <= '0;
      sclk_q  <= 1'b0;
      frame_q <= 1'b0;
    end else if (start_i && !frame_q) begin
      hc_q    <= '0;
      half_q  <= half_i;
      ec_q    <= '0;
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
    end else if (frame_q) begin
      if (expire) begin
        hc_q <= '0;
        if (done_o) begin
          frame_q <= 1'b0;
        end else begin
          ec_q   <= ec_q + EW'(1);
          sclk_q <= ~sclk_q;
        end
      end else begin
        hc_q <= hc_q + CW'(1);
      end
    end
  end

  // R1
  shift_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> frame_o);
  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_q |-> !sclk_q);
  // R2
  frame_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !frame_o);
endmodule

// File: rtl/srp_slave_edge.sv
module srp_slave_edge #(
  parameter int unsigned WORD_W = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic inv_i,
  input  logic clr_i,
  output logic upd_o,
  output logic in_prog_o
);
  localparam int unsigned SCW = $clog2(WORD_W + 2);

  logic           s1_q, s2_q, s3_q;
  logic [SCW-1:0] cnt_q;

  assign upd_o     = en_i && !cs_ni && (s2_q ^ inv_i) && !(s3_q ^ inv_i);
  assign in_prog_o = (cnt_q != '0) && (cnt_q < SCW'(WORD_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= sclk_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (clr_i)                    cnt_q <= '0;
      else if (upd_o && ~&cnt_q)    cnt_q <= cnt_q + SCW'(1);
    end
  end

  // R7
  cs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(cnt_q) || cnt_q == '0);
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int unsigned WORD_W    = srp_pkg::RES_W,
  parameter int unsigned HALF_DIV0 = 3,
  parameter int unsigned HALF_DIV1 = 8,
  parameter int unsigned HALF_DIV2 = 15,
  parameter int unsigned HALF_DIV3 = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              conv_done_i,
  input  logic [WORD_W-1:0] result_i,
  input  logic              slave_mode_i,
  input  logic              sync_inv_i,
  input  logic              sclk_inv_i,
  input  logic              rd_during_i,
  input  logic [1:0]        div_sel_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              sync_o,
  output logic              sync_oe_o,
  output logic              sdout_o,
  output logic              sdout_oe_o,
  output logic              busy_o,
  output logic              rd_err_o
);
  import srp_pkg::*;

  localparam int unsigned CW = $clog2(HALF_DIV3 + 1);

  logic [WORD_W-1:0] sreg_q, res_q;
  logic [CW-1:0]     half;
  logic              busy_q, rac_frame_q, rd_err_q;
  logic              m_rac, m_rdc, m_start, m_sclk, m_frame, m_shift, m_done;
  logic              s_upd, s_in_prog, load_new;
  div_code_e         code;

  assign m_rac    = !slave_mode_i && !rd_during_i;
  assign m_rdc    = !slave_mode_i && rd_during_i;
  assign m_start  = (m_rac && conv_done_i) || (m_rdc && conv_start_i);
  assign load_new = conv_done_i && (slave_mode_i || !rd_during_i);
  assign code     = m_rdc ? DIV_C0 : div_code_e'(div_sel_i);

  always_comb begin
    case (code)
      DIV_C0:  half = CW'(HALF_DIV0);
      DIV_C1:  half = CW'(HALF_DIV1);
      DIV_C2:  half = CW'(HALF_DIV2);
      default: half = CW'(HALF_DIV3);
    endcase
  end

  srp_master_clk #(.WORD_W(WORD_W), .CW(CW)) u_mclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (m_start),
    .half_i  (half),
    .sclk_o  (m_sclk),
    .frame_o (m_frame),
    .shift_o (m_shift),
    .done_o  (m_done)
  );

  srp_slave_edge #(.WORD_W(WORD_W)) u_sedge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (slave_mode_i),
    .cs_ni     (cs_ni),
    .sclk_i    (sclk_i),
    .inv_i     (sclk_inv_i),
    .clr_i     (conv_done_i),
    .upd_o     (s_upd),
    .in_prog_o (s_in_prog)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q      <= '0;
      res_q       <= '0;
      busy_q      <= 1'b0;
      rac_frame_q <= 1'b0;
      rd_err_q    <= 1'b0;
    end else begin
      if (conv_done_i) res_q <= result_i;

      if (load_new)                       sreg_q <= result_i;
      else if (m_rdc && conv_start_i && !m_frame) sreg_q <= res_q;
      else if (m_shift)                   sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      else if (s_upd)                     sreg_q <= {sreg_q[WORD_W-2:0], sdin_i};

      if (m_start && !m_frame) rac_frame_q <= m_rac;

      if (conv_start_i)                    busy_q <= 1'b1;
      else if (conv_done_i && !m_rac)      busy_q <= 1'b0;
      else if (m_done && rac_frame_q)      busy_q <= 1'b0;

      rd_err_q <= conv_done_i && slave_mode_i && s_in_prog;
    end
  end

  assign sclk_o     = m_sclk ^ sclk_inv_i;
  assign sync_o     = m_frame ^ sync_inv_i;
  assign sdout_o    = sreg_q[WORD_W-1];
  assign sclk_oe_o  = !cs_ni && !slave_mode_i;
  assign sync_oe_o  = !cs_ni && !slave_mode_i;
  assign sdout_oe_o = !cs_ni;
  assign busy_o     = busy_q;
  assign rd_err_o   = rd_err_q;

  // R4
  rac_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_frame && rac_frame_q) |-> busy_q);
  // R9
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_q |=> !rd_err_q);
  // R8
  chain_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_upd && !conv_done_i) |=> sreg_q[0] == $past(sdin_i));
endmodule

// File: tb/serial_result_port_tb.sv
`timescale 1ns/1ps
module serial_result_port_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        conv_start_i = 0, conv_done_i = 0;
  logic [17:0] result_i = '0;
  logic        slave_mode_i = 0, sync_inv_i = 0, sclk_inv_i = 0, rd_during_i = 0;
  logic [1:0]  div_sel_i = 0;
  logic        cs_ni = 0, sclk_i = 0, sdin_i = 0;
  logic        sclk_o, sclk_oe_o, sync_o, sync_oe_o, sdout_o, sdout_oe_o, busy_o, rd_err_o;

  serial_result_port u_dut (.clk_i(clk), .*);

  always #2 clk = ~clk;

  int   n_chk = 0, n_bad = 0, exp_half = 3, err_cnt = 0, gap = 0;
  logic exp_q[$];
  bit   mon_en = 0;
  logic prev_raw = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] c);
    case (c)
      2'd0: return 3;
      2'd1: return 8;
      2'd2: return 15;
      default: return 30;
    endcase
  endfunction

  // monitor: pops expected bits on the master sample edge
  always @(negedge clk) begin
    logic raw;
    logic e;
    if (rd_err_o) err_cnt++;
    raw = sclk_o ^ sclk_inv_i;
    if (mon_en && sclk_oe_o && raw != prev_raw) begin
      if (!raw) begin
        if (exp_q.size() == 0) chk(0, "R1 extra bit", sdout_o, 0);
        else begin
          e = exp_q.pop_front();
          chk(sdout_o === e, "R1 data bit", sdout_o, e);
        end
        chk(gap + 1 == exp_half, "R6 half period", gap + 1, exp_half);
        chk(sync_o == !sync_inv_i, "R2 sync active", sync_o, !sync_inv_i);
      end
      gap = 0;
    end else gap++;
    prev_raw = raw;
  end

  task automatic pulse_start();
    conv_start_i = 1; @(negedge clk); conv_start_i = 0;
  endtask

  task automatic pulse_done(input logic [17:0] d);
    result_i = d; conv_done_i = 1; @(negedge clk); conv_done_i = 0;
  endtask

  task automatic push_word(input logic [17:0] d);
    for (int i = 17; i >= 0; i--) exp_q.push_back(d[i]);
  endtask

  task automatic master_rac(input logic [17:0] d, input logic [1:0] div,
                            input logic inv, input logic sinv);
    bit busy_drop = 0;
    slave_mode_i = 0; rd_during_i = 0; div_sel_i = div;
    sclk_inv_i = inv; sync_inv_i = sinv; cs_ni = 0;
    @(negedge clk);
    prev_raw = 0; exp_half = half_of(div); mon_en = 1;
    chk(sclk_o == inv, "R3 idle level", sclk_o, inv);
    chk(sync_o == sinv, "R2 idle sync", sync_o, sinv);
    chk(sclk_oe_o && sync_oe_o && sdout_oe_o, "R10 master enables", 0, 1);
    pulse_start();
    repeat (4) @(negedge clk);
    chk(busy_o == 1, "R4 busy in conversion", busy_o, 1);
    push_word(d);
    pulse_done(d);
    chk(sync_o == !sinv, "R4 frame at completion", sync_o, !sinv);
    while (sync_o != sinv) begin
      if (!busy_o) busy_drop = 1;
      @(negedge clk);
    end
    chk(!busy_drop, "R4 busy held in frame", busy_drop, 0);
    chk(busy_o == 0, "R4 busy falls with sync", busy_o, 0);
    chk(exp_q.size() == 0, "R1 bit count", exp_q.size(), 0);
    exp_q.delete();
    mon_en = 0;
  endtask

  task automatic master_rdc(input logic [17:0] a, input logic [17:0] b);
    slave_mode_i = 0; rd_during_i = 1; div_sel_i = 2'd3;
    sclk_inv_i = 0; sync_inv_i = 0; cs_ni = 0;
    @(negedge clk);
    prev_raw = 0; exp_half = 3; mon_en = 1;
    pulse_done(a);
    chk(sync_o == 0, "R5 no frame at completion", sync_o, 0);
    push_word(a);
    pulse_start();
    repeat (40) @(negedge clk);
    chk(busy_o == 1, "R5 busy in conversion", busy_o, 1);
    chk(sync_o == 1, "R5 frame during conversion", sync_o, 1);
    pulse_done(b);
    chk(busy_o == 0, "R5 busy falls at completion", busy_o, 0);
    chk(sync_o == 1, "R5 frame continues", sync_o, 1);
    while (sync_o) @(negedge clk);
    chk(exp_q.size() == 0, "R5 old word complete", exp_q.size(), 0);
    exp_q.delete();
    push_word(b);
    pulse_start();
    while (!sync_o) @(negedge clk);
    while (sync_o) @(negedge clk);
    chk(exp_q.size() == 0, "R5 next word used", exp_q.size(), 0);
    exp_q.delete();
    pulse_done(18'h0);
    mon_en = 0;
  endtask

  task automatic edge_pair(input logic inv);
    sclk_i = ~inv; repeat (6) @(negedge clk);
    sclk_i = inv;  repeat (6) @(negedge clk);
  endtask

  task automatic slave_read(input logic [17:0] d, input logic [7:0] din,
                            input int n, input logic inv);
    logic e;
    slave_mode_i = 1; sclk_inv_i = inv; sclk_i = inv; cs_ni = 1; sdin_i = 0;
    repeat (4) @(negedge clk);
    pulse_done(d);
    chk(!sdout_oe_o && !sclk_oe_o && !sync_oe_o, "R10 disabled with cs high",
        {sdout_oe_o, sclk_oe_o, sync_oe_o}, 0);
    for (int i = 0; i < 3; i++) edge_pair(inv);
    cs_ni = 0; repeat (4) @(negedge clk);
    chk(sclk_oe_o == 0 && sdout_oe_o == 1, "R10 slave enables",
        {sclk_oe_o, sdout_oe_o}, 1);
    push_word(d);
    for (int j = 0; j < n; j++) exp_q.push_back(din[j]);
    for (int i = 0; i < 18 + n; i++) begin
      e = exp_q.pop_front();
      if (i < 18) chk(sdout_o === e, "R7 slave bit", sdout_o, e);
      else        chk(sdout_o === e, "R8 chained bit", sdout_o, e);
      sdin_i = (i < n) ? din[i] : 1'b0;
      edge_pair(inv);
    end
    cs_ni = 1; @(negedge clk);
  endtask

  task automatic slave_abort();
    int e0;
    slave_mode_i = 1; sclk_inv_i = 0; sclk_i = 0; cs_ni = 0; sdin_i = 0;
    repeat (4) @(negedge clk);
    pulse_done(18'h2AAAA);
    for (int i = 0; i < 5; i++) edge_pair(0);
    e0 = err_cnt;
    pulse_done(18'h15555);
    repeat (3) @(negedge clk);
    chk(err_cnt - e0 == 1, "R9 one error pulse", err_cnt - e0, 1);
    chk(sdout_o == 1'b0, "R9 new word replaces", sdout_o, 0);
    push_word(18'h15555);
    for (int i = 0; i < 18; i++) begin
      logic e;
      e = exp_q.pop_front();
      chk(sdout_o === e, "R9 reread bit", sdout_o, e);
      edge_pair(0);
    end
    e0 = err_cnt;
    pulse_done(18'h3FFFF);
    repeat (3) @(negedge clk);
    chk(err_cnt == e0, "R9 no error after full read", err_cnt - e0, 0);
    cs_ni = 1; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(busy_o == 0, "R11 busy reset", busy_o, 0);
    chk(rd_err_o == 0, "R11 error reset", rd_err_o, 0);
    chk(sync_o == 0, "R11 sync inactive", sync_o, 0);
    chk(sclk_o == 0, "R11 clock idle", sclk_o, 0);
    master_rac(18'h2C3A5, 2'd0, 0, 0);
    master_rac(18'h1F00F, 2'd1, 1, 1);
    master_rac(18'h3FFFE, 2'd2, 0, 1);
    master_rac(18'h00001, 2'd3, 1, 0);
    master_rdc(18'h25A5A, 18'h0F0F1);
    slave_read(18'h3A5C3, 8'h00, 0, 0);
    slave_read(18'h1234B, 8'hB5, 8, 1);
    slave_abort();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule